// File: doc/BRIEF.md
# E1 Timeslot-0 Overhead Bit Inserter

This block sits in the transmit direction of a 2.048 Mbit/s E1 stream, one bit per clock, on its way to a line interface. It counts its position within the 16-frame CRC-4 multiframe and rewrites the overhead bits carried in timeslot 0. There is one mode control for each field: the remote-alarm bit, the two spare bits Sa7 and Sa8, the two E bits, and the four CRC-4 bits. A field can pass through unchanged, be sourced from one of two 8-bit bit buffers, be forced, or be recomputed. Every other bit of the stream leaves the block exactly one clock after it entered.

An external sync pulse realigns the position counter. A mode bit sets how the pulse is read: as the start of a frame or as the start of a multiframe. The block holds a shadow copy of all controls and both bit buffers. It copies them in on the first bit of each multiframe, so a change made part way through a multiframe has no effect until the next one begins. In automatic mode the E bits report the receive-side CRC-4 check result back to the far end.

Top module: `e1oh_inserter`

## Requirements
- R1: While `rst` is high, `dout` is 0. Reset sets the position to bit 0 of frame 0, clears all shadow controls (so the block is disabled and passes data through), and clears the stored CRC-4 remainder.
- R2: When the shadow enable is 0, every output bit equals the input bit of the previous clock, overhead positions included.
- R3: The alarm bit is bit 3 of timeslot 0 (frame bit index 2) in odd frame 2k+1. When its mode bit is 0 it passes through. When its mode bit is 1 it takes buffer-0 bit k.
- R4: Sa7 and Sa8 are frame bit indices 6 and 7 of odd frame 2k+1. Each has its own mode bit. At 0 the bit passes through; at 1 it takes buffer-1 bit k.
- R5: The E bits are bit index 0 of frames 13 and 15. The 2-bit E mode is decoded as follows: 00 passes through, 01 takes buffer-0 bit k (k = 6 or 7), 10 selects automatic, and 11 behaves as 00.
- R6: In automatic E mode, each E bit is 0 while `rx_crc_err` is 1 and 1 while it is 0. The input is sampled at the bit's own clock.
- R7: The C bits are bit index 0 of the even frames. The 2-bit CRC mode is decoded as follows: 00 passes through, 01 forces 1, 10 recomputes, and 11 behaves as 00.
- R8: The recomputed remainder uses x^4+x+1 over the 2048 output bits of each 8-frame half-multiframe, with the C positions counted as 0. Even frames 0/2/4/6 of the next half carry remainder bits 3/2/1/0.
- R9: Controls and bit buffers are sampled on the first bit of each multiframe (frame 0, bit index 0) and held for the whole multiframe.
- R10: In multiframe sync mode (shadow sync bit 1), a `sync_in` pulse makes the current bit frame 0, bit index 0.
- R11: In frame sync mode (shadow sync bit 0), a `sync_in` pulse makes the current bit bit index 0 and leaves the frame number unchanged.
- R12: Non-overhead bits, and the odd-frame bits that carry no selected field, leave unchanged with a one-clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Incoming serial E1 bit |
| sync_in | input | 1 | Alignment pulse, marks bit index 0 of a frame or multiframe |
| ctl_enable | input | 1 | Enables overhead rewriting |
| ctl_sync_mf | input | 1 | 1: sync marks a multiframe; 0: sync marks a frame |
| ctl_a_buf | input | 1 | Alarm bit source: 1 = buffer 0 |
| ctl_sa7_buf | input | 1 | Sa7 source: 1 = buffer 1 |
| ctl_sa8_buf | input | 1 | Sa8 source: 1 = buffer 1 |
| ctl_e_mode | input | 2 | E-bit mode |
| ctl_crc_mode | input | 2 | CRC-4 bit mode |
| bitbuf0 | input | FRAMES/2 | Buffer 0, bit k for odd frame 2k+1 |
| bitbuf1 | input | FRAMES/2 | Buffer 1, bit k for odd frame 2k+1 |
| rx_crc_err | input | 1 | Receive CRC-4 check failed |
| dout | output | 1 | Outgoing serial bit |

## Verification
Every output bit is due exactly one clock after its input bit. The bench drives each bit on a falling edge, predicts the output from the requirements, and compares it on the next falling edge, after the single output register has updated. A control change takes effect only in the clock where the position next reaches frame 0, bit index 0. A recomputed remainder first appears in the half-multiframe after the one it covers. Because of this, the bench keeps its own position counter and its own serial remainder, and tags each compare with the requirement that governs that bit.

// File: rtl/e1oh_pkg.sv
package e1oh_pkg;

    typedef enum logic [1:0] {
        EM_PASS = 2'b00,
        EM_BUF  = 2'b01,
        EM_AUTO = 2'b10,
        EM_BAD  = 2'b11
    } ebit_mode_e;

    typedef enum logic [1:0] {
        CM_PASS = 2'b00,
        CM_ONES = 2'b01,
        CM_CALC = 2'b10,
        CM_BAD  = 2'b11
    } crc_mode_e;

    typedef enum logic [2:0] {
        F_NONE,
        F_CRC,
        F_EBIT,
        F_ABIT,
        F_SA7,
        F_SA8
    } field_e;

    typedef struct packed {
        logic       enable;
        logic       mf_sync;
        logic       a_buf;
        logic       sa7_buf;
        logic       sa8_buf;
        ebit_mode_e e_mode;
        crc_mode_e  c_mode;
    } ohctl_t;

    localparam int unsigned A_POS   = 2;
    localparam int unsigned SA7_POS = 6;
    localparam int unsigned SA8_POS = 7;

    // Which overhead field, if any, a (frame, bit) position carries.
    function automatic field_e classify(input int unsigned frame,
                                        input int unsigned bpos,
                                        input int unsigned frames);
        field_e f;
        f = F_NONE;
        if (frame % 2 == 0) begin
            if (bpos == 0) f = F_CRC;
        end else begin
            if (bpos == 0 && (frame == frames - 3 || frame == frames - 1))
                f = F_EBIT;
            else if (bpos == A_POS)
                f = F_ABIT;
            else if (bpos == SA7_POS)
                f = F_SA7;
            else if (bpos == SA8_POS)
                f = F_SA8;
        end
        return f;
    endfunction

    // One serial step of the x^4+x+1 division.
    function automatic logic [3:0] crc4_step(input logic [3:0] c, input logic b);
        logic fb;
        fb = b ^ c[3];
        return {c[2], c[1], c[0] ^ fb, fb};
    endfunction

endpackage

// File: rtl/e1oh_position.sv
module e1oh_position #(
    parameter int FRAME_BITS = 256,
    parameter int FRAMES     = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          sync_in,
    input  logic                          mf_mode,
    output logic [$clog2(FRAME_BITS)-1:0] bit_idx,
    output logic [$clog2(FRAMES)-1:0]     frame_idx,
    output logic                          mf_start
);
    localparam int BW = $clog2(FRAME_BITS);
    localparam int FW = $clog2(FRAMES);

    logic [BW-1:0] bit_q;
    logic [FW-1:0] frm_q;

    always_comb begin
        bit_idx   = bit_q;
        frame_idx = frm_q;
        if (sync_in) begin
            bit_idx = '0;
            if (mf_mode) frame_idx = '0;
        end
        mf_start = (bit_idx == '0) && (frame_idx == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q <= '0;
            frm_q <= '0;
        end else if (bit_idx == BW'(FRAME_BITS - 1)) begin
            bit_q <= '0;
            frm_q <= (frame_idx == FW'(FRAMES - 1)) ? '0 : frame_idx + 1'b1;
        end else begin
            bit_q <= bit_idx + 1'b1;
            frm_q <= frame_idx;
        end
    end
endmodule

// File: rtl/e1oh_ctl_latch.sv
module e1oh_ctl_latch
    import e1oh_pkg::*;
#(
    parameter int NB = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mf_start,
    input  ohctl_t        ctl_in,
    input  logic [NB-1:0] b0_in,
    input  logic [NB-1:0] b1_in,
    output ohctl_t        ctl_act,
    output logic [NB-1:0] b0_act,
    output logic [NB-1:0] b1_act,
    output logic          mf_sync_q
);
    ohctl_t        ctl_q;
    logic [NB-1:0] b0_q;
    logic [NB-1:0] b1_q;

    // Boundary bit already uses the fresh values.
    always_comb begin
        if (mf_start) begin
            ctl_act = ctl_in;
            b0_act  = b0_in;
            b1_act  = b1_in;
        end else begin
            ctl_act = ctl_q;
            b0_act  = b0_q;
            b1_act  = b1_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            b0_q  <= '0;
            b1_q  <= '0;
        end else begin
            ctl_q <= ctl_act;
            b0_q  <= b0_act;
            b1_q  <= b1_act;
        end
    end

    assign mf_sync_q = ctl_q.mf_sync;
endmodule

// File: rtl/e1oh_crc4.sv
module e1oh_crc4
    import e1oh_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_in,
    input  logic       smf_first,
    input  logic       smf_last,
    output logic [3:0] crc_hold
);
    logic [3:0] acc_q;
    logic [3:0] acc_nx;

    always_comb begin
        acc_nx = crc4_step(smf_first ? 4'h0 : acc_q, bit_in);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            crc_hold <= '0;
        end else begin
            acc_q <= acc_nx;
            if (smf_last) crc_hold <= acc_nx;
        end
    end
endmodule

// File: rtl/e1oh_inserter.sv
module e1oh_inserter
    import e1oh_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    parameter int FRAMES     = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  din,
    input  logic                  sync_in,
    input  logic                  ctl_enable,
    input  logic                  ctl_sync_mf,
    input  logic                  ctl_a_buf,
    input  logic                  ctl_sa7_buf,
    input  logic                  ctl_sa8_buf,
    input  logic [1:0]            ctl_e_mode,
    input  logic [1:0]            ctl_crc_mode,
    input  logic [FRAMES/2-1:0]   bitbuf0,
    input  logic [FRAMES/2-1:0]   bitbuf1,
    input  logic                  rx_crc_err,
    output logic                  dout
);
    localparam int BW = $clog2(FRAME_BITS);
    localparam int FW = $clog2(FRAMES);
    localparam int NB = FRAMES / 2;

    logic [BW-1:0] bit_idx;
    logic [FW-1:0] frame_idx;
    logic          mf_start;
    logic          mf_sync_q;
    ohctl_t        ctl_in;
    ohctl_t        cfg_act;
    logic [NB-1:0] buf0_act;
    logic [NB-1:0] buf1_act;
    logic [3:0]    crc_hold;
    field_e        field;
    logic [FW-2:0] odd_idx;
    logic [FW-3:0] c_idx;
    logic          out_bit;
    logic          crc_feed;
    logic          smf_first;
    logic          smf_last;

    always_comb begin
        ctl_in.enable  = ctl_enable;
        ctl_in.mf_sync = ctl_sync_mf;
        ctl_in.a_buf   = ctl_a_buf;
        ctl_in.sa7_buf = ctl_sa7_buf;
        ctl_in.sa8_buf = ctl_sa8_buf;
        ctl_in.e_mode  = ebit_mode_e'(ctl_e_mode);
        ctl_in.c_mode  = crc_mode_e'(ctl_crc_mode);
    end

    e1oh_position #(.FRAME_BITS(FRAME_BITS), .FRAMES(FRAMES)) u_pos (
        .clk       (clk),
        .rst       (rst),
        .sync_in   (sync_in),
        .mf_mode   (mf_sync_q),
        .bit_idx   (bit_idx),
        .frame_idx (frame_idx),
        .mf_start  (mf_start)
    );

    e1oh_ctl_latch #(.NB(NB)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .mf_start  (mf_start),
        .ctl_in    (ctl_in),
        .b0_in     (bitbuf0),
        .b1_in     (bitbuf1),
        .ctl_act   (cfg_act),
        .b0_act    (buf0_act),
        .b1_act    (buf1_act),
        .mf_sync_q (mf_sync_q)
    );

    assign odd_idx   = frame_idx[FW-1:1];
    assign c_idx     = frame_idx[FW-2:1];
    assign smf_first = (bit_idx == '0) && (frame_idx[FW-2:0] == '0);
    assign smf_last  = (bit_idx == BW'(FRAME_BITS - 1)) && (&frame_idx[FW-2:0]);

    always_comb begin
        field   = classify(32'(frame_idx), 32'(bit_idx), FRAMES);
        out_bit = din;
        if (cfg_act.enable) begin
            unique case (field)
                F_ABIT: if (cfg_act.a_buf)   out_bit = buf0_act[odd_idx];
                F_SA7:  if (cfg_act.sa7_buf) out_bit = buf1_act[odd_idx];
                F_SA8:  if (cfg_act.sa8_buf) out_bit = buf1_act[odd_idx];
                F_EBIT: begin
                    case (cfg_act.e_mode)
                        EM_BUF:  out_bit = buf0_act[odd_idx];
                        EM_AUTO: out_bit = ~rx_crc_err;
                        default: out_bit = din;
                    endcase
                end
                F_CRC: begin
                    case (cfg_act.c_mode)
                        CM_ONES: out_bit = 1'b1;
                        CM_CALC: out_bit = crc_hold[3 - int'(c_idx)];
                        default: out_bit = din;
                    endcase
                end
                default: out_bit = din;
            endcase
        end
        crc_feed = (field == F_CRC) ? 1'b0 : out_bit;
    end

    e1oh_crc4 u_crc (
        .clk       (clk),
        .rst       (rst),
        .bit_in    (crc_feed),
        .smf_first (smf_first),
        .smf_last  (smf_last),
        .crc_hold  (crc_hold)
    );

    always_ff @(posedge clk) begin
        if (rst) dout <= 1'b0;
        else     dout <= out_bit;
    end
endmodule

// File: rtl/e1oh_chk.sv
module e1oh_chk
    import e1oh_pkg::*;
#(
    parameter int NB = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  din,
    input logic                  dout,
    input logic                  rx_crc_err,
    input logic                  mf_start,
    input field_e                field,
    input ohctl_t                cfg_act,
    input logic [NB-1:0]         buf0_act,
    input logic [NB-1:0]         buf1_act,
    input logic [$clog2(NB)-1:0] odd_idx
);
    // R2
    disabled_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_act.enable |=> dout == $past(din));

    // R12
    plain_bit_chk: assert property (@(posedge clk) disable iff (rst)
        field == F_NONE |=> dout == $past(din));

    // R3
    abit_buf_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_act.enable && field == F_ABIT && cfg_act.a_buf)
        |=> dout == $past(buf0_act[odd_idx]));

    // R4
    sa8_buf_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_act.enable && field == F_SA8 && cfg_act.sa8_buf)
        |=> dout == $past(buf1_act[odd_idx]));

    // R6
    ebit_auto_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_act.enable && field == F_EBIT && cfg_act.e_mode == EM_AUTO)
        |=> dout == !$past(rx_crc_err));

    // R7
    crc_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_act.enable && field == F_CRC && cfg_act.c_mode == CM_ONES)
        |=> dout);

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !mf_start |-> $stable(cfg_act) && $stable(buf0_act) && $stable(buf1_act));
endmodule

bind e1oh_inserter e1oh_chk #(.NB(FRAMES / 2)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .din        (din),
    .dout       (dout),
    .rx_crc_err (rx_crc_err),
    .mf_start   (mf_start),
    .field      (field),
    .cfg_act    (cfg_act),
    .buf0_act   (buf0_act),
    .buf1_act   (buf1_act),
    .odd_idx    (odd_idx)
);

// File: tb/tb_e1oh_inserter.sv
module tb_e1oh_inserter;
    localparam int FB = 256;
    localparam int NF = 16;
    localparam int NB = NF / 2;
    localparam int MF = FB * NF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic sync_in = 1'b0;
    logic c_en = 1'b0, c_mf = 1'b0, c_a = 1'b0, c_s7 = 1'b0, c_s8 = 1'b0;
    logic [1:0] c_e = 2'b00, c_c = 2'b00;
    logic [NB-1:0] b0 = '0, b1 = '0;
    logic rx_err = 1'b0;
    logic dout;

    always #2 clk = ~clk;

    e1oh_inserter #(.FRAME_BITS(FB), .FRAMES(NF)) dut (
        .clk(clk), .rst(rst), .din(din), .sync_in(sync_in),
        .ctl_enable(c_en), .ctl_sync_mf(c_mf), .ctl_a_buf(c_a),
        .ctl_sa7_buf(c_s7), .ctl_sa8_buf(c_s8), .ctl_e_mode(c_e),
        .ctl_crc_mode(c_c), .bitbuf0(b0), .bitbuf1(b1),
        .rx_crc_err(rx_err), .dout(dout)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            if (n_bad <= 20)
                $display("FAIL %s: dout=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Bench-side expectation state
    int m_bit = 0, m_frm = 0;
    logic k_en = 0, k_mf = 0, k_a = 0, k_s7 = 0, k_s8 = 0;
    logic [1:0] k_e = 0, k_c = 0;
    logic [NB-1:0] k_b0 = '0, k_b1 = '0;
    logic [3:0] m_acc = 0, m_hold = 0;
    logic exp_bit = 0, have_exp = 0;
    string exp_tag = "R1";
    int sync_tag = 0;
    logic sync_kind = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic predict();
        int cb, cf, k, fld;
        logic ob, cbit, fb, pending;
        string tg;
        cb = m_bit;
        cf = m_frm;
        if (sync_in) begin
            cb = 0;
            if (k_mf) cf = 0;
            sync_tag  = 300;
            sync_kind = k_mf;
        end
        if (cb == 0 && cf == 0) begin
            k_en = c_en; k_mf = c_mf; k_a = c_a; k_s7 = c_s7; k_s8 = c_s8;
            k_e = c_e; k_c = c_c; k_b0 = b0; k_b1 = b1;
        end
        pending = ({c_en, c_mf, c_a, c_s7, c_s8, c_e, c_c} !=
                   {k_en, k_mf, k_a, k_s7, k_s8, k_e, k_c}) || (b0 != k_b0) || (b1 != k_b1);
        k = cf / 2;
        fld = 0;
        if (cf % 2 == 0 && cb == 0) fld = 1;
        else if (cf % 2 == 1 && cb == 0 && (cf == 13 || cf == 15)) fld = 2;
        else if (cf % 2 == 1 && cb == 2) fld = 3;
        else if (cf % 2 == 1 && cb == 6) fld = 4;
        else if (cf % 2 == 1 && cb == 7) fld = 5;
        ob = din;
        tg = "R12";
        case (fld)
            1: begin
                if (k_c == 2'b01) begin ob = 1'b1; tg = "R7"; end
                else if (k_c == 2'b10) begin ob = m_hold[3 - (cf % 8) / 2]; tg = "R8"; end
                else tg = "R7";
            end
            2: begin
                if (k_e == 2'b01) begin ob = k_b0[k]; tg = "R5"; end
                else if (k_e == 2'b10) begin ob = ~rx_err; tg = "R6"; end
                else tg = "R5";
            end
            3: begin tg = "R3"; if (k_a)  ob = k_b0[k]; end
            4: begin tg = "R4"; if (k_s7) ob = k_b1[k]; end
            5: begin tg = "R4"; if (k_s8) ob = k_b1[k]; end
            default: ;
        endcase
        if (!k_en) begin ob = din; tg = "R2"; end
        cbit = (fld == 1) ? 1'b0 : ob;
        if (cb == 0 && cf % 8 == 0) m_acc = 4'h0;
        fb = cbit ^ m_acc[3];
        m_acc = {m_acc[2], m_acc[1], m_acc[0] ^ fb, fb};
        if (cb == FB - 1 && cf % 8 == 7) m_hold = m_acc;
        if (cb == FB - 1) begin m_bit = 0; m_frm = (cf + 1) % NF; end
        else begin m_bit = cb + 1; m_frm = cf; end
        if (pending) tg = "R9";
        if (sync_tag > 0) begin tg = sync_kind ? "R10" : "R11"; sync_tag--; end
        exp_bit  = ob;
        exp_tag  = tg;
        have_exp = 1'b1;
    endtask

    // Drive one bit now (just after a falling edge), compare one edge later.
    task automatic tick(input logic s);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        din = lfsr[0];
        sync_in = s;
        predict();
        @(negedge clk);
        check(exp_tag, dout, exp_bit);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick(1'b0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(190000 * 4);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, got hang expected finish");
        summary();
    end

    initial begin
        // R1: output held low through reset
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R1", dout, 1'b0);
        end
        rst = 1'b0;

        // R1/R2: reset leaves the block disabled, so data passes through
        run(MF + 100);

        // R10: switch to multiframe sync, then realign mid-multiframe
        c_en = 1'b1; c_mf = 1'b1;
        run(MF + 500);
        tick(1'b1);
        run(MF + 50);

        // R3 R4 R5 R7: buffer-sourced fields, forced C bits
        c_a = 1'b1; c_s7 = 1'b1; c_s8 = 1'b1; c_e = 2'b01; c_c = 2'b01;
        b0 = 8'hA5; b1 = 8'h3C;
        run(MF + 1000);
        // R9: buffers changed mid-multiframe, held until the boundary
        b0 = 8'h5A; b1 = 8'hC3;
        run(MF);

        // R6 R8: automatic E bits with a toggling check result, recomputed CRC
        c_e = 2'b10; c_c = 2'b10; c_a = 1'b0;
        for (int j = 0; j < 40; j++) begin
            rx_err = j[0];
            run(3 * MF / 40);
        end
        run(MF);

        // R5 R7: illegal codes behave as pass-through
        c_e = 2'b11; c_c = 2'b11; c_s7 = 1'b0;
        run(MF + 200);

        // R11: frame-qualifier sync realigns bit position only
        c_mf = 1'b0; c_c = 2'b10;
        run(MF);
        run(777);
        tick(1'b1);
        run(2 * MF);

        // R2: disable again
        c_en = 1'b0;
        run(MF + 300);

        summary();
    end
endmodule